// File: doc/BRIEF.md
# Power Button Long-Press Shutdown Controller

This block sits between a debounced power-button level and the platform's power state machine. It asks the state machine to power the host on when the button is pressed, or the lid is opened, while the chipset reports an off state. It also asks for a forced shutdown when the button is held for a long time. The long-press timer counts ticks of a 1 ms strobe. Releasing the button stops the timer and drops the pending shutdown.

A second path handles suspend. If the host finishes its move from running into suspend while the button is still held, the shutdown request is raised at once and the timer is dropped. The shutdown request then stays high until the state machine reports that it has reached full power-off.

The block also holds the active-low system reset line. A one-cycle reset command drives that line low for one tick period and then releases it.

Top module: `pwr_btn_guard`

## Requirements
- R1: A rising edge of `btnPressed` in a cycle where `chipOff` is high makes `powerOnReq` high for exactly the next cycle.
- R2: A rising edge of `lidOpen` while `chipOff` is high also gives a one-cycle `powerOnReq`. A button or lid edge while `chipOff` is low gives no request.
- R3: Each press starts the hold timer from zero. If the button stays held for `HOLD_TICKS` ticks (default 8000, one tick per ms), `forceShutdown` rises in the cycle after the last of those ticks.
- R4: Releasing the button before the timer expires cancels the pending shutdown. A release in the same cycle as the final tick also cancels it.
- R5: A `suspendDone` strobe while `btnPressed` is high sets `forceShutdown` in the next cycle and cancels the timer. A later `inG3` clears the request, and further ticks with the button still held do not raise it again.
- R6: Once set, `forceShutdown` stays high until a cycle with `inG3` high, and it is low from the next cycle. If a set condition and `inG3` fall in the same cycle, the set wins.
- R7: A new press after a release restarts the hold count from zero, so the full `HOLD_TICKS` ticks are needed again.
- R8: A `resetCmd` strobe drives `sysRstN` low from the next cycle. `sysRstN` returns high in the cycle after the `RST_TICKS`-th tick (default 1) that follows the command. A command in the same cycle as a tick restarts the count.
- R9: After reset, `powerOnReq` and `forceShutdown` are low and `sysRstN` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | One-cycle 1 ms strobe |
| btnPressed | input | 1 | Debounced button level, high while held |
| lidOpen | input | 1 | Lid level, high while open |
| chipOff | input | 1 | Chipset is in an off state |
| suspendDone | input | 1 | One-cycle strobe: the transition from running to suspend has finished |
| inG3 | input | 1 | State machine reports full power-off |
| resetCmd | input | 1 | One-cycle system reset command |
| powerOnReq | output | 1 | One-cycle power-on request |
| forceShutdown | output | 1 | Forced shutdown request, level |
| sysRstN | output | 1 | Active-low system reset |

## Verification
Three pairs of events can fall in the same cycle.

- Button release and the final timer tick. The bench holds the button for one tick fewer than the limit, then drops the level in the same cycle as the last tick. It then expects `forceShutdown` to stay low through many more ticks.
- A set condition and the G3 report. The bench pulses `suspendDone` and `inG3` together with the button held, and expects the request to be set.
- A reset command and a tick. The bench issues the command in a tick cycle and expects the line to stay low until a later tick.

// File: rtl/pwr_btn_pkg.sv
package pwr_btn_pkg;
  // Strobes from the control section to the timer datapath.
  typedef struct packed {
    logic arm;       // press edge: restart the hold count
    logic cancel;    // release, or suspend reached while held
    logic rstStart;  // begin a system reset pulse
  } ctlStrobes_t;
endpackage

// File: rtl/pwr_btn_timer.sv
module pwr_btn_timer
  import pwr_btn_pkg::*;
#(
  parameter int HOLD_TICKS = 8000,
  parameter int RST_TICKS  = 1
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        tick,
  input  ctlStrobes_t strb,
  output logic        expire,
  output logic        sysRstN
);
  localparam int HW = $clog2(HOLD_TICKS + 1);
  localparam int RW = $clog2(RST_TICKS + 1);
  localparam logic [HW-1:0] HOLD_LAST = HW'(HOLD_TICKS - 1);
  localparam logic [RW-1:0] RST_LAST  = RW'(RST_TICKS - 1);

  logic          armed;
  logic [HW-1:0] holdCnt;
  logic          rstLow;
  logic [RW-1:0] rstCnt;

  // Cancel and a fresh arm both suppress expiry in their cycle.
  assign expire = tick && armed && (holdCnt == HOLD_LAST) && !strb.cancel && !strb.arm;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      armed   <= 1'b0;
      holdCnt <= '0;
    end else if (strb.cancel) begin
      armed <= 1'b0;
    end else if (strb.arm) begin
      armed   <= 1'b1;
      holdCnt <= '0;
    end else if (tick && armed) begin
      if (holdCnt == HOLD_LAST) armed <= 1'b0;
      else                      holdCnt <= holdCnt + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rstLow <= 1'b0;
      rstCnt <= '0;
    end else if (strb.rstStart) begin
      rstLow <= 1'b1;
      rstCnt <= '0;
    end else if (rstLow && tick) begin
      if (rstCnt == RST_LAST) rstLow <= 1'b0;
      else                    rstCnt <= rstCnt + 1'b1;
    end
  end

  assign sysRstN = !rstLow;
endmodule

// File: rtl/pwr_btn_ctrl.sv
module pwr_btn_ctrl
  import pwr_btn_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        btnPressed,
  input  logic        lidOpen,
  input  logic        chipOff,
  input  logic        suspendDone,
  input  logic        inG3,
  input  logic        resetCmd,
  input  logic        expire,
  output ctlStrobes_t strb,
  output logic        powerOnReq,
  output logic        forceShutdown
);
  logic btnPrev;
  logic lidPrev;
  logic pressEdge;
  logic lidEdge;
  logic suspendHeld;

  assign pressEdge   = btnPressed && !btnPrev;
  assign lidEdge     = lidOpen && !lidPrev;
  assign suspendHeld = suspendDone && btnPressed;

  always_comb begin
    strb.arm      = pressEdge;
    strb.cancel   = !btnPressed || suspendHeld;
    strb.rstStart = resetCmd;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      btnPrev       <= 1'b0;
      lidPrev       <= 1'b0;
      powerOnReq    <= 1'b0;
      forceShutdown <= 1'b0;
    end else begin
      btnPrev    <= btnPressed;
      lidPrev    <= lidOpen;
      powerOnReq <= (pressEdge || lidEdge) && chipOff;
      // A set condition wins over the G3 clear.
      if (expire || suspendHeld) forceShutdown <= 1'b1;
      else if (inG3)             forceShutdown <= 1'b0;
    end
  end
endmodule

// File: rtl/pwr_btn_guard.sv
module pwr_btn_guard
  import pwr_btn_pkg::*;
#(
  parameter int HOLD_TICKS = 8000,
  parameter int RST_TICKS  = 1
) (
  input  logic clk,
  input  logic rstN,
  input  logic tick,
  input  logic btnPressed,
  input  logic lidOpen,
  input  logic chipOff,
  input  logic suspendDone,
  input  logic inG3,
  input  logic resetCmd,
  output logic powerOnReq,
  output logic forceShutdown,
  output logic sysRstN
);
  ctlStrobes_t strb;
  logic        expire;

  pwr_btn_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .btnPressed(btnPressed), .lidOpen(lidOpen),
    .chipOff(chipOff), .suspendDone(suspendDone), .inG3(inG3),
    .resetCmd(resetCmd), .expire(expire), .strb(strb),
    .powerOnReq(powerOnReq), .forceShutdown(forceShutdown)
  );

  pwr_btn_timer #(.HOLD_TICKS(HOLD_TICKS), .RST_TICKS(RST_TICKS)) u_timer (
    .clk(clk), .rstN(rstN), .tick(tick), .strb(strb),
    .expire(expire), .sysRstN(sysRstN)
  );
endmodule

// File: rtl/pwr_btn_guard_chk.sv
module pwr_btn_guard_chk (
  input logic clk,
  input logic rstN,
  input logic btnPressed,
  input logic chipOff,
  input logic suspendDone,
  input logic inG3,
  input logic resetCmd,
  input logic powerOnReq,
  input logic forceShutdown,
  input logic sysRstN
);
  p_pulse_r1: assert property (@(posedge clk) disable iff (!rstN)
    powerOnReq |=> !powerOnReq);

  p_press_off_r1: assert property (@(posedge clk) disable iff (!rstN)
    ($rose(btnPressed) && chipOff) |=> powerOnReq);

  p_only_off_r2: assert property (@(posedge clk) disable iff (!rstN)
    powerOnReq |-> $past(chipOff));

  p_suspend_r5: assert property (@(posedge clk) disable iff (!rstN)
    (suspendDone && btnPressed) |=> forceShutdown);

  p_hold_r6: assert property (@(posedge clk) disable iff (!rstN)
    (forceShutdown && !inG3) |=> forceShutdown);

  p_clear_r6: assert property (@(posedge clk) disable iff (!rstN)
    (forceShutdown && inG3 && !btnPressed) |=> !forceShutdown);

  p_rst_low_r8: assert property (@(posedge clk) disable iff (!rstN)
    resetCmd |=> !sysRstN);
endmodule

bind pwr_btn_guard pwr_btn_guard_chk u_chk (
  .clk(clk), .rstN(rstN), .btnPressed(btnPressed), .chipOff(chipOff),
  .suspendDone(suspendDone), .inG3(inG3), .resetCmd(resetCmd),
  .powerOnReq(powerOnReq), .forceShutdown(forceShutdown), .sysRstN(sysRstN)
);

// File: tb/pwr_btn_guard_test.sv
`timescale 1ns/1ps
module pwr_btn_guard_test;
  localparam int HOLD = 8000;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic tick = 1'b0, btnPressed = 1'b0, lidOpen = 1'b0, chipOff = 1'b0;
  logic suspendDone = 1'b0, inG3 = 1'b0, resetCmd = 1'b0;
  logic powerOnReq, forceShutdown, sysRstN;
  int total = 0;
  int bad = 0;

  always #4 clk = ~clk;

  pwr_btn_guard uut (
    .clk(clk), .rstN(rstN), .tick(tick), .btnPressed(btnPressed),
    .lidOpen(lidOpen), .chipOff(chipOff), .suspendDone(suspendDone),
    .inG3(inG3), .resetCmd(resetCmd), .powerOnReq(powerOnReq),
    .forceShutdown(forceShutdown), .sysRstN(sysRstN)
  );

  task automatic chk(input string req, input logic act, input logic exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%b expected=%b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic cyc(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      tick = 1'b1; @(negedge clk);
      tick = 1'b0; @(negedge clk);
    end
  endtask

  task automatic clearForce();
    inG3 = 1'b1; @(negedge clk);
    inG3 = 1'b0;
  endtask

  task automatic t_reset();
    chk("R9 powerOnReq", powerOnReq, 1'b0);
    chk("R9 forceShutdown", forceShutdown, 1'b0);
    chk("R9 sysRstN", sysRstN, 1'b1);
  endtask

  task automatic t_press_off();
    chipOff = 1'b1; btnPressed = 1'b1; @(negedge clk);
    chk("R1 request after press while off", powerOnReq, 1'b1);
    @(negedge clk);
    chk("R1 request lasts one cycle", powerOnReq, 1'b0);
    btnPressed = 1'b0; chipOff = 1'b0; cyc(2);
  endtask

  task automatic t_press_on();
    btnPressed = 1'b1; @(negedge clk);
    chk("R2 no request from press while on", powerOnReq, 1'b0);
    btnPressed = 1'b0; cyc(2);
  endtask

  task automatic t_lid();
    chipOff = 1'b1; lidOpen = 1'b1; @(negedge clk);
    chk("R2 lid open while off requests", powerOnReq, 1'b1);
    cyc(3);
    chk("R2 lid held gives no second request", powerOnReq, 1'b0);
    lidOpen = 1'b0; chipOff = 1'b0; cyc(1);
    lidOpen = 1'b1; @(negedge clk);
    chk("R2 lid open while on no request", powerOnReq, 1'b0);
    lidOpen = 1'b0; cyc(1);
  endtask

  task automatic t_longpress();
    btnPressed = 1'b1; cyc(1);
    ticks(HOLD - 1);
    chk("R3 not yet expired", forceShutdown, 1'b0);
    ticks(1);
    chk("R3 expired after full hold", forceShutdown, 1'b1);
    btnPressed = 1'b0; ticks(20);
    chk("R6 stays set until G3", forceShutdown, 1'b1);
    clearForce();
    chk("R6 cleared by G3", forceShutdown, 1'b0);
  endtask

  task automatic t_release_cancel();
    btnPressed = 1'b1; cyc(1);
    ticks(100);
    btnPressed = 1'b0; cyc(1);
    ticks(HOLD);
    chk("R4 release cancels", forceShutdown, 1'b0);
  endtask

  task automatic t_release_same();
    btnPressed = 1'b1; cyc(1);
    ticks(HOLD - 1);
    tick = 1'b1; btnPressed = 1'b0; @(negedge clk);
    tick = 1'b0; @(negedge clk);
    chk("R4 release on final tick cancels", forceShutdown, 1'b0);
    ticks(10);
    chk("R4 still no shutdown", forceShutdown, 1'b0);
  endtask

  task automatic t_repress();
    btnPressed = 1'b1; cyc(1);
    ticks(5000);
    btnPressed = 1'b0; cyc(1);
    btnPressed = 1'b1; cyc(1);
    ticks(HOLD - 1);
    chk("R7 restart needs full count", forceShutdown, 1'b0);
    ticks(1);
    chk("R7 expires after full restarted count", forceShutdown, 1'b1);
    btnPressed = 1'b0; clearForce(); cyc(1);
  endtask

  task automatic t_suspend();
    btnPressed = 1'b1; cyc(1);
    ticks(10);
    suspendDone = 1'b1; @(negedge clk);
    suspendDone = 1'b0;
    chk("R5 immediate shutdown on suspend while held", forceShutdown, 1'b1);
    clearForce();
    chk("R5 G3 clears", forceShutdown, 1'b0);
    ticks(HOLD);
    chk("R5 timer was cancelled", forceShutdown, 1'b0);
    btnPressed = 1'b0; cyc(1);
    suspendDone = 1'b1; @(negedge clk);
    suspendDone = 1'b0;
    chk("R5 suspend without press no shutdown", forceShutdown, 1'b0);
  endtask

  task automatic t_set_wins();
    btnPressed = 1'b1; cyc(1);
    suspendDone = 1'b1; inG3 = 1'b1; @(negedge clk);
    suspendDone = 1'b0; inG3 = 1'b0;
    chk("R6 set wins over G3 clear", forceShutdown, 1'b1);
    btnPressed = 1'b0; clearForce();
    chk("R6 cleared afterwards", forceShutdown, 1'b0);
  endtask

  task automatic t_reset_pulse();
    resetCmd = 1'b1; @(negedge clk);
    resetCmd = 1'b0;
    chk("R8 reset line low after command", sysRstN, 1'b0);
    cyc(5);
    chk("R8 held low without tick", sysRstN, 1'b0);
    ticks(1);
    chk("R8 released after one tick", sysRstN, 1'b1);
    resetCmd = 1'b1; tick = 1'b1; @(negedge clk);
    resetCmd = 1'b0; tick = 1'b0; @(negedge clk);
    chk("R8 command on tick restarts", sysRstN, 1'b0);
    ticks(1);
    chk("R8 released after later tick", sysRstN, 1'b1);
  endtask

  initial begin
    cyc(3);
    rstN = 1'b1;
    cyc(2);
    t_reset();
    t_press_off();
    t_press_on();
    t_lid();
    t_longpress();
    t_release_cancel();
    t_release_same();
    t_repress();
    t_suspend();
    t_set_wins();
    t_reset_pulse();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog: actual=running expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule